// File: doc/BRIEF.md
# System-Control Coprocessor with Interrupt Entry and Return

This block is the system-control coprocessor of a small 32-bit in-order pipeline. It keeps nine control registers. Software reads and writes them through a move-to / move-from port that selects a register by a 5-bit number and a 3-bit select. Three hardware interrupt lines feed pending bits in the cause register. Two of them are level inputs from a serial port: the transmitter can take a character, and a received character is waiting. The third is raised inside the block when the free-running cycle counter matches the compare register.

When interrupts are globally enabled, the pipeline is not already in exception level, and at least one pending line is unmasked, the block takes an interrupt. It does so for the instruction presented as valid in the execute stage. It records that instruction's PC, enters exception level, and pulses a redirect toward the handler at exception base + 0x180. A return-from-exception request leaves exception level and redirects to the saved PC. Flushing the pipeline on a redirect is the requester's job.

Top module: `ccp_core`

## Requirements
- R1: Registers are addressed by {number, select}: user-local 4/2, fault address 8/0, cycle counter 9/0, compare 11/0, status 12/0, cause 13/0, exception PC 14/0, exception base 15/1, configuration 16/0. Any other pair reads 0. `acc_rdata` shows, one cycle after the address is applied, the value held before any write in that same cycle.
- R2: After a synchronous reset, status, cause, user-local, exception PC and fault address read 0. Exception base reads 0x80000000, compare reads 0xFFFFFFFF, and `redirect` is 0.
- R3: In status, only bit 0 (IE), bit 1 (EXL) and bits 15:8 (interrupt mask) are writable, and all other bits read 0. In exception base, only bits 29:12 are writable, bits 31:30 read 2'b10 and bits 11:0 read 0.
- R4: The cycle counter increments by one every clock. A write to it loads the written value.
- R5: Cause bit 15 (timer pending) sets on the clock after the counter equals compare. It stays set until compare is written, and that write clears it.
- R6: Cause bit 10 follows `irq_tx_ready` and cause bit 11 follows `irq_rx_ready`. Cause bits 6:2 (exception code) read 0, meaning interrupt. Software writes to cause have no effect.
- R7: An interrupt is taken only in a cycle with `ex_valid`=1, IE=1 and EXL=0, and with some cause bit in 15:8 set whose status mask bit is also set.
- R8: Taking an interrupt sets EXL and loads the exception PC with `ex_pc`. On the next cycle it raises `redirect` for one cycle with `redirect_pc` = {exception base[31:12], 12'h180}.
- R9: `eret_req` clears EXL and raises `redirect` on the next cycle, with `redirect_pc` equal to the saved exception PC.
- R10: The fault-address register loads `fault_addr` when `fault_strobe` is 1. Software writes to it are ignored.
- R11: Several unmasked pending lines at once produce exactly one interrupt entry. Software tells the sources apart by reading cause.
- R12: A status or exception-PC write in the same cycle as an interrupt entry is discarded, and the entry's update wins.
- R13: The configuration register reads a fixed value, 0x80000000 by default, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_num | input | 5 | Register number for a move access |
| acc_sel | input | 3 | Register select for a move access |
| acc_wr | input | 1 | Move-to write strobe |
| acc_wdata | input | 32 | Move-to write data |
| acc_rdata | output | 32 | Registered move-from read data |
| irq_tx_ready | input | 1 | Serial transmitter can accept a character |
| irq_rx_ready | input | 1 | Serial receiver holds a character |
| ex_valid | input | 1 | A valid instruction occupies the execute stage |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| eret_req | input | 1 | Return-from-exception request |
| fault_strobe | input | 1 | Capture strobe for a faulting address |
| fault_addr | input | 32 | Faulting address |
| redirect | output | 1 | One-cycle PC redirect pulse |
| redirect_pc | output | 32 | Target PC while `redirect` is 1 |

## Verification
Several properties are checked on every clock:
- that interrupt entry sets EXL, saves the PC and produces the vectored redirect on the following cycle;
- that a return clears EXL and redirects to the saved PC;
- that the counter steps by one unless written;
- that the timer pending bit holds until compare is written and rises only after a match;
- that the fault address changes only on its strobe;
- that two entries never come back to back.

Other behaviour shows only in the bench's scenarios:
- the exact cycle on which a timer match turns into a redirect;
- the field masks and the effect of a relocated exception base;
- that masked sources and exception level block entry;
- that a write colliding with an entry is lost;
- that software writes to cause, fault address and configuration do nothing.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int DW = 32;
  localparam int IM_W = 8;
  localparam int IRQ_TX_BIT = 2;
  localparam int IRQ_RX_BIT = 3;
  localparam int IRQ_TMR_BIT = 7;

  typedef enum logic [3:0] {
    REG_NONE, REG_ULOCAL, REG_BADV, REG_COUNT, REG_COMPARE,
    REG_STATUS, REG_CAUSE, REG_EPC, REG_EBASE, REG_CONFIG
  } cop_reg_e;

  function automatic cop_reg_e ccp_decode(input logic [4:0] num, input logic [2:0] sel);
    case ({num, sel})
      {5'd4,  3'd2}: return REG_ULOCAL;
      {5'd8,  3'd0}: return REG_BADV;
      {5'd9,  3'd0}: return REG_COUNT;
      {5'd11, 3'd0}: return REG_COMPARE;
      {5'd12, 3'd0}: return REG_STATUS;
      {5'd13, 3'd0}: return REG_CAUSE;
      {5'd14, 3'd0}: return REG_EPC;
      {5'd15, 3'd1}: return REG_EBASE;
      {5'd16, 3'd0}: return REG_CONFIG;
      default:       return REG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ccp_timer.sv
module ccp_timer #(
  parameter int W = 32,
  parameter logic [W-1:0] CMP_RESET = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] compare,
  output logic         pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      compare <= CMP_RESET;
      pend    <= 1'b0;
    end else begin
      count <= cnt_wr ? wdata : count + 1'b1;
      if (cmp_wr) compare <= wdata;
      if (cmp_wr) pend <= 1'b0;
      else if (count == compare) pend <= 1'b1;
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> count == $past(count) + 1'b1);
  assert_timer_hold_R5: assert property (@(posedge clk) disable iff (rst)
    pend && !cmp_wr |=> pend);
  assert_timer_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(count == compare));
endmodule

// File: rtl/ccp_irq_gate.sv
module ccp_irq_gate #(
  parameter int N = 8
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  input  logic         ie,
  input  logic         exl,
  input  logic         ex_valid,
  output logic         take
);
  logic [N-1:0] live;
  always_comb begin
    live = pend & mask;
    take = ex_valid && ie && !exl && (|live);
  end
endmodule

// File: rtl/ccp_core.sv
module ccp_core import ccp_pkg::*; #(
  parameter logic [31:0] EBASE_RESET  = 32'h8000_0000,
  parameter logic [31:0] CONFIG_VALUE = 32'h8000_0000,
  parameter logic [11:0] VEC_OFFSET   = 12'h180
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    acc_num,
  input  logic [2:0]    acc_sel,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  input  logic          irq_tx_ready,
  input  logic          irq_rx_ready,
  input  logic          ex_valid,
  input  logic [DW-1:0] ex_pc,
  input  logic          eret_req,
  input  logic          fault_strobe,
  input  logic [DW-1:0] fault_addr,
  output logic          redirect,
  output logic [DW-1:0] redirect_pc
);
  localparam int EB_LO = 12;
  localparam int EB_HI = 29;
  localparam int IM_LSB = 8;

  cop_reg_e sel_reg;
  logic wr_cnt, wr_cmp, wr_st, wr_epc, wr_ul, wr_eb;
  logic [DW-1:0] count, compare, ulocal, badv, epc, ebase_rd, status_rd, cause_rd, vec;
  logic [EB_HI-EB_LO:0] ebase_mid;
  logic [IM_W-1:0] im, hw_pend;
  logic ie, exl, tmr_pend, take;

  always_comb begin
    sel_reg = ccp_decode(acc_num, acc_sel);
    wr_cnt  = acc_wr && (sel_reg == REG_COUNT);
    wr_cmp  = acc_wr && (sel_reg == REG_COMPARE);
    wr_st   = acc_wr && (sel_reg == REG_STATUS);
    wr_epc  = acc_wr && (sel_reg == REG_EPC);
    wr_ul   = acc_wr && (sel_reg == REG_ULOCAL);
    wr_eb   = acc_wr && (sel_reg == REG_EBASE);
    hw_pend = '0;
    hw_pend[IRQ_TX_BIT]  = irq_tx_ready;
    hw_pend[IRQ_RX_BIT]  = irq_rx_ready;
    hw_pend[IRQ_TMR_BIT] = tmr_pend;
    status_rd = {16'h0, im, 6'h0, exl, ie};
    cause_rd  = {16'h0, hw_pend, 8'h0};
    ebase_rd  = {EBASE_RESET[31:30], ebase_mid, 12'h0};
    vec       = {ebase_rd[31:12], VEC_OFFSET};
  end

  ccp_timer #(.W(DW), .CMP_RESET({DW{1'b1}})) u_timer (
    .clk(clk), .rst(rst), .cnt_wr(wr_cnt), .cmp_wr(wr_cmp), .wdata(acc_wdata),
    .count(count), .compare(compare), .pend(tmr_pend)
  );

  ccp_irq_gate #(.N(IM_W)) u_gate (
    .pend(hw_pend), .mask(im), .ie(ie), .exl(exl), .ex_valid(ex_valid), .take(take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie          <= 1'b0;
      exl         <= 1'b0;
      im          <= '0;
      epc         <= '0;
      ulocal      <= '0;
      badv        <= '0;
      ebase_mid   <= EBASE_RESET[EB_HI:EB_LO];
      redirect    <= 1'b0;
      redirect_pc <= '0;
      acc_rdata   <= '0;
    end else begin
      redirect    <= take || eret_req;
      redirect_pc <= take ? vec : epc;
      if (take) begin
        exl <= 1'b1;
        epc <= ex_pc;
      end else begin
        if (eret_req) exl <= 1'b0;
        else if (wr_st) begin
          ie  <= acc_wdata[0];
          exl <= acc_wdata[1];
          im  <= acc_wdata[IM_LSB +: IM_W];
        end
        if (wr_epc) epc <= acc_wdata;
      end
      if (wr_ul) ulocal <= acc_wdata;
      if (wr_eb) ebase_mid <= acc_wdata[EB_HI:EB_LO];
      if (fault_strobe) badv <= fault_addr;
      case (sel_reg)
        REG_ULOCAL:  acc_rdata <= ulocal;
        REG_BADV:    acc_rdata <= badv;
        REG_COUNT:   acc_rdata <= count;
        REG_COMPARE: acc_rdata <= compare;
        REG_STATUS:  acc_rdata <= status_rd;
        REG_CAUSE:   acc_rdata <= cause_rd;
        REG_EPC:     acc_rdata <= epc;
        REG_EBASE:   acc_rdata <= ebase_rd;
        REG_CONFIG:  acc_rdata <= CONFIG_VALUE;
        default:     acc_rdata <= '0;
      endcase
    end
  end

  assert_entry_exl_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> exl);
  assert_entry_epc_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> epc == $past(ex_pc));
  assert_entry_vector_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> redirect && redirect_pc == $past(vec));
  assert_return_R9: assert property (@(posedge clk) disable iff (rst)
    eret_req && !take |=> !exl && redirect && redirect_pc == $past(epc));
  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !fault_strobe |=> $stable(badv));
  assert_single_entry_R11: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);
endmodule

// File: tb/test_ccp_core.sv
module test_ccp_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] acc_num = '0;
  logic [2:0] acc_sel = '0;
  logic acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic irq_tx_ready = 1'b0, irq_rx_ready = 1'b0, ex_valid = 1'b0, eret_req = 1'b0;
  logic fault_strobe = 1'b0;
  logic [31:0] ex_pc = '0, fault_addr = '0, redirect_pc;
  logic redirect;
  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ccp_core i_ccp_core (
    .clk(clk), .rst(rst), .acc_num(acc_num), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_tx_ready(irq_tx_ready),
    .irq_rx_ready(irq_rx_ready), .ex_valid(ex_valid), .ex_pc(ex_pc), .eret_req(eret_req),
    .fault_strobe(fault_strobe), .fault_addr(fault_addr), .redirect(redirect),
    .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cp_write(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_num = n; acc_sel = s; acc_wr = 1'b1; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic cp_read(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    acc_num = n; acc_sel = s; acc_wr = 1'b0;
    @(negedge clk);
    v = acc_rdata;
  endtask

  task automatic count_redirects(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (redirect) hits++;
    end
  endtask

  function automatic logic [31:0] model_write(input int idx, input logic [31:0] old, input logic [31:0] d);
    case (idx)
      3: return 32'h8000_0000 | (d & 32'h3FFF_F000);
      4: return old;
      5: return d & 32'h0000_FF03;
      default: return d;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mdl [6];
    logic [4:0] nums [6];
    logic [2:0] sels [6];
    int hits;
    nums = '{5'd4, 5'd11, 5'd14, 5'd15, 5'd8, 5'd12};
    sels = '{3'd2, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0};
    mdl  = '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000, 32'h0, 32'h0};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 redirect after reset", {31'h0, redirect}, 32'h0);
    cp_read(5'd12, 3'd0, v); chk("R2 status reset", v, 32'h0);
    cp_read(5'd13, 3'd0, v); chk("R2 cause reset", v, 32'h0);
    cp_read(5'd15, 3'd1, v); chk("R2 ebase reset", v, 32'h8000_0000);
    cp_read(5'd11, 3'd0, v); chk("R2 compare reset", v, 32'hFFFF_FFFF);
    cp_read(5'd16, 3'd0, v); chk("R13 config value", v, 32'h8000_0000);
    cp_write(5'd16, 3'd0, 32'h1234_5678);
    cp_read(5'd16, 3'd0, v); chk("R13 config write ignored", v, 32'h8000_0000);
    cp_read(5'd4, 3'd0, v); chk("R1 unmapped 4/0", v, 32'h0);
    cp_read(5'd9, 3'd1, v); chk("R1 unmapped 9/1", v, 32'h0);

    // R1 latency: same-cycle read returns old value, then the new one
    cp_write(5'd4, 3'd2, 32'hCAFE_0001);
    chk("R1 read shows pre-write value", acc_rdata, 32'h0);
    @(negedge clk);
    chk("R1 read after write", acc_rdata, 32'hCAFE_0001);
    mdl[0] = 32'hCAFE_0001;

    // constrained random writes and readbacks, R3 masks and R10 ignore
    for (int k = 0; k < 30; k++) begin
      int idx;
      logic [31:0] d;
      idx = int'($urandom % 6);
      d = $urandom;
      if (idx == 5) d = d & 32'hFFFF_FFFE;
      cp_write(nums[idx], sels[idx], d);
      mdl[idx] = model_write(idx, mdl[idx], d);
      cp_read(nums[idx], sels[idx], v);
      chk("R3/R10 random register readback", v, mdl[idx]);
    end
    cp_write(5'd12, 3'd0, 32'hFFFF_FFFF);
    cp_read(5'd12, 3'd0, v); chk("R3 status mask", v, 32'h0000_FF03);
    cp_write(5'd12, 3'd0, 32'h0);
    cp_write(5'd15, 3'd1, 32'h8000_0000);

    // R10 fault address capture
    @(negedge clk); fault_strobe = 1'b1; fault_addr = 32'h0BAD_F00D;
    @(negedge clk); fault_strobe = 1'b0;
    cp_read(5'd8, 3'd0, v); chk("R10 fault capture", v, 32'h0BAD_F00D);
    cp_write(5'd8, 3'd0, 32'h1111_2222);
    cp_read(5'd8, 3'd0, v); chk("R10 fault write ignored", v, 32'h0BAD_F00D);

    // R6 cause write ignored
    cp_write(5'd13, 3'd0, 32'hFFFF_FFFF);
    cp_read(5'd13, 3'd0, v); chk("R6 cause write ignored", v, 32'h0);

    // R4 counter stepping
    cp_write(5'd9, 3'd0, 32'h0000_5000);
    repeat (10) @(negedge clk);
    chk("R4 counter steps", acc_rdata, 32'h0000_5009);

    // R5/R8 timer interrupt with exact timing
    cp_write(5'd12, 3'd0, 32'h0000_8001);
    cp_write(5'd11, 3'd0, 32'h0010_0000);
    cp_write(5'd9, 3'd0, 32'h000F_FFFB);
    ex_valid = 1'b1; ex_pc = 32'h0040_1230;
    repeat (6) @(negedge clk);
    chk("R5 no redirect before match", {31'h0, redirect}, 32'h0);
    @(negedge clk);
    chk("R5 redirect on timer", {31'h0, redirect}, 32'h1);
    chk("R8 default vector", redirect_pc, 32'h8000_0180);
    @(negedge clk);
    chk("R8 redirect one cycle", {31'h0, redirect}, 32'h0);
    ex_valid = 1'b0;
    cp_read(5'd13, 3'd0, v); chk("R5 timer pending in cause", v, 32'h0000_8000);
    cp_read(5'd12, 3'd0, v); chk("R8 EXL set", v, 32'h0000_8003);
    cp_read(5'd14, 3'd0, v); chk("R8 EPC saved", v, 32'h0040_1230);
    cp_write(5'd11, 3'd0, 32'hFFFF_0000);
    cp_read(5'd13, 3'd0, v); chk("R5 compare write clears", v, 32'h0);

    // R9 return
    @(negedge clk); eret_req = 1'b1;
    @(negedge clk); eret_req = 1'b0;
    chk("R9 redirect on return", {31'h0, redirect}, 32'h1);
    chk("R9 return target", redirect_pc, 32'h0040_1230);
    cp_read(5'd12, 3'd0, v); chk("R9 EXL cleared", v, 32'h0000_8001);
    cp_write(5'd12, 3'd0, 32'h0);

    // R12 status write collides with entry
    irq_tx_ready = 1'b1;
    cp_write(5'd12, 3'd0, 32'h0000_0401);
    @(negedge clk);
    acc_num = 5'd12; acc_sel = 3'd0; acc_wr = 1'b1; acc_wdata = 32'h0;
    ex_valid = 1'b1; ex_pc = 32'h0040_2000;
    @(negedge clk);
    acc_wr = 1'b0; ex_valid = 1'b0;
    chk("R12 entry taken", {31'h0, redirect}, 32'h1);
    cp_read(5'd12, 3'd0, v); chk("R12 status write lost", v, 32'h0000_0403);
    // R12 EPC write collides with entry
    cp_write(5'd12, 3'd0, 32'h0000_0401);
    @(negedge clk);
    acc_num = 5'd14; acc_sel = 3'd0; acc_wr = 1'b1; acc_wdata = 32'hDEAD_0000;
    ex_valid = 1'b1; ex_pc = 32'h0040_3000;
    @(negedge clk);
    acc_wr = 1'b0; ex_valid = 1'b0;
    cp_read(5'd14, 3'd0, v); chk("R12 EPC write lost", v, 32'h0040_3000);
    irq_tx_ready = 1'b0;
    cp_write(5'd12, 3'd0, 32'h0);

    // R7 masking, EXL block; R8 relocated base
    cp_write(5'd15, 3'd1, 32'h9ABC_DFFF);
    cp_read(5'd15, 3'd1, v); chk("R3 ebase mask", v, 32'h9ABC_D000);
    irq_rx_ready = 1'b1; ex_valid = 1'b1; ex_pc = 32'h0040_4000;
    cp_write(5'd12, 3'd0, 32'h0000_0001);
    count_redirects(8, hits); chk("R7 masked source ignored", hits, 0);
    cp_read(5'd13, 3'd0, v); chk("R6 rx pending in cause", v, 32'h0000_0800);
    cp_write(5'd12, 3'd0, 32'h0000_0803);
    count_redirects(8, hits); chk("R7 EXL blocks entry", hits, 0);
    cp_write(5'd12, 3'd0, 32'h0000_0800);
    count_redirects(8, hits); chk("R7 IE clear blocks entry", hits, 0);
    cp_write(5'd12, 3'd0, 32'h0000_0801);
    @(negedge clk);
    chk("R7 entry when enabled", {31'h0, redirect}, 32'h1);
    chk("R8 relocated vector", redirect_pc, 32'h9ABC_D180);
    ex_valid = 1'b0; irq_rx_ready = 1'b0;
    cp_write(5'd12, 3'd0, 32'h0);
    cp_write(5'd15, 3'd1, 32'h8000_0000);

    // R11 two sources, one entry
    irq_tx_ready = 1'b1; irq_rx_ready = 1'b1; ex_valid = 1'b1;
    cp_write(5'd12, 3'd0, 32'h0000_0C01);
    count_redirects(10, hits); chk("R11 single entry", hits, 1);
    ex_valid = 1'b0;
    cp_read(5'd13, 3'd0, v); chk("R11 cause shows both", v, 32'h0000_0C00);
    irq_tx_ready = 1'b0; irq_rx_ready = 1'b0;
    cp_read(5'd13, 3'd0, v); chk("R6 cause follows inputs", v, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule